// File: doc/BRIEF.md
# Asynchronous Byte Framer with Serial Host Readout

This block recovers 8-bit characters from an asynchronous serial line that has already been demodulated. The line is sampled once per system clock, and the system clock runs at a fixed multiple (`OSR`, default 16) of the bit rate. A character is a low start bit, eight data bits sent least significant bit first, and a high stop bit. The receiver confirms the start bit in the middle of the bit and samples each later bit in its middle. A character that ends well is copied into a separate holding register, and an active-low ready flag then tells the host that a byte is waiting.

The host reads the byte out serially with its own data clock. The holding register shows its lowest bit on the data pin, and each rising edge of the host clock moves the next bit onto it. The first host edge also returns the ready flag high. If the host never clocks, the flag goes high by itself after half a bit time. Because readout uses the holding register, the receiver can take in the next character at the same time without disturbing the byte being read. The host clock and the line input come from outside the system clock domain, so each passes through a two-stage synchronizer.

Top module: `async_byte_framer`

## Requirements
- R1: A frame is start bit 0, then data bits b0..b7 in that order (least significant first), then stop bit 1. A good frame places the byte, as b7..b0 = bits 7..0, in the holding register.
- R2: A low level that has gone back high by the middle of the start bit is dropped as a glitch. It produces no ready flag and no framing error.
- R3: A frame whose stop bit samples 0 is discarded. No ready flag is raised, and `ferr_o` is high for exactly one clock.
- R4: `rdy_n_o` goes low on the clock after a good frame is stored in the holding register.
- R5: A rising edge on `hclk_i` returns `rdy_n_o` high three clocks after the edge reaches the input (two synchronizer stages plus one edge register).
- R6: With no host clock edge, `rdy_n_o` stays low for exactly `READY_CYC` clocks (default `OSR/2`, half a bit time) and then goes high.
- R7: `sdata_o` shows b0 once a byte is stored. Each rising edge of `hclk_i` moves on one bit, b1 through b7. After b7 the pin reads 1.
- R8: A character being received does not change the holding register. Readout of the stored byte goes on undisturbed until the new character's stop bit is accepted.
- R9: While `en_i` is low the receiver stays idle. Frames on the line raise neither a ready flag nor a framing error.
- R10: After a framing error the receiver waits for the line to go high before it looks for a new start bit, so a line held low does not cause repeated errors.
- R11: After reset `rdy_n_o` is 1, `ferr_o` is 0 and `sdata_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, `OSR` times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en_i | input | 1 | Receiver enable |
| rx_bit_i | input | 1 | Demodulated serial line |
| hclk_i | input | 1 | Host data clock; rising edge moves readout forward |
| sdata_o | output | 1 | Serial readout data |
| rdy_n_o | output | 1 | Active-low byte-ready flag |
| ferr_o | output | 1 | One-clock framing-error pulse |

## Verification
On every cycle, the assertions check how the ready flag relates to its causes. It falls only after a load, it rises after a host edge, and its timer never goes past its limit. They also check that the holding register shifts on each host edge, that a framing error and a good character are never reported together and that each error pulse lasts one cycle, that a disabled receiver stays quiet, and that the receiver does not leave its wait-for-high state while the line is low. Only the bench scenarios can show the rest: that whole byte values come out LSB first, that a glitch is dropped, that a long low line after a bad stop bit causes exactly one error, and that readout interleaved with a second reception returns the old bits and then the new byte.

// File: rtl/abf_pkg.sv
package abf_pkg;
  typedef enum logic [2:0] {
    RX_IDLE   = 3'd0,
    RX_START  = 3'd1,
    RX_DATA   = 3'd2,
    RX_STOP   = 3'd3,
    RX_WAITHI = 3'd4
  } rx_state_e;
endpackage

// File: rtl/abf_sync.sv
module abf_sync #(
  parameter int unsigned          W       = 1,
  parameter int unsigned          STAGES  = 2,
  parameter logic [W-1:0]         RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;
  logic [STAGES-1:0][W-1:0] pipe_d;

  always_comb begin
    pipe_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) pipe_d[s] = pipe_q[s-1];
  end

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[g] <= RST_VAL;
        else        pipe_q[g] <= pipe_d[g];
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/abf_rx.sv
module abf_rx
  import abf_pkg::*;
#(
  parameter int unsigned OSR    = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              rx_s_i,
  output logic              done_o,
  output logic              ferr_o,
  output logic [DATA_W-1:0] byte_o
);
  localparam int unsigned CW   = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int unsigned BW   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int unsigned HALF = OSR / 2;
  localparam logic [CW-1:0] CNT_LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] CNT_MID  = CW'(HALF - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(DATA_W - 1);

  rx_state_e         state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [DATA_W-1:0] sr_q, sr_d;
  logic              done_q, done_d;
  logic              ferr_q, ferr_d;
  logic              tick;

  assign tick = (cnt_q == CNT_LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sr_d    = sr_q;
    done_d  = 1'b0;
    ferr_d  = 1'b0;
    case (state_q)
      RX_IDLE: begin
        if (!rx_s_i) begin
          state_d = RX_START;
          cnt_d   = '0;
        end
      end
      RX_START: begin
        if (cnt_q == CNT_MID) begin
          cnt_d = '0;
          if (!rx_s_i) begin
            state_d = RX_DATA;
            bit_d   = '0;
          end else begin
            state_d = RX_IDLE;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      RX_DATA: begin
        if (tick) begin
          cnt_d = '0;
          sr_d  = {rx_s_i, sr_q[DATA_W-1:1]};
          if (bit_q == BIT_LAST) state_d = RX_STOP;
          else                   bit_d   = bit_q + 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      RX_STOP: begin
        if (tick) begin
          cnt_d = '0;
          if (rx_s_i) begin
            done_d  = 1'b1;
            state_d = RX_IDLE;
          end else begin
            ferr_d  = 1'b1;
            state_d = RX_WAITHI;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      RX_WAITHI: begin
        if (rx_s_i) state_d = RX_IDLE;
      end
      default: state_d = RX_IDLE;
    endcase
    if (!en_i) begin
      state_d = RX_IDLE;
      done_d  = 1'b0;
      ferr_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sr_q    <= '0;
      done_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sr_q    <= sr_d;
      done_q  <= done_d;
      ferr_q  <= ferr_d;
    end
  end

  assign done_o = done_q;
  assign ferr_o = ferr_q;
  assign byte_o = sr_q;

  // R3
  ferr_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && ferr_q));
  // R9
  en_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && $past(!en_i)) |-> (!done_q && !ferr_q));
  // R10
  waithi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_WAITHI && !rx_s_i && en_i) |=> (state_q == RX_WAITHI));
endmodule

// File: rtl/abf_readout.sv
module abf_readout #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned READY_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              hclk_s_i,
  output logic              sdata_o,
  output logic              rdy_n_o
);
  localparam int unsigned TW = $clog2(READY_CYC + 1);
  localparam logic [TW-1:0] TMR_INIT = TW'(READY_CYC - 1);

  logic [DATA_W-1:0] hold_q, hold_d;
  logic [TW-1:0]     tmr_q, tmr_d;
  logic              rdy_n_q, rdy_n_d;
  logic              hclk_q;
  logic              rise;

  assign rise = hclk_s_i & ~hclk_q;

  always_comb begin
    hold_d  = hold_q;
    tmr_d   = tmr_q;
    rdy_n_d = rdy_n_q;
    if (load_i) begin
      hold_d  = din_i;
      rdy_n_d = 1'b0;
      tmr_d   = TMR_INIT;
    end else begin
      if (rise) hold_d = {1'b1, hold_q[DATA_W-1:1]};
      if (!rdy_n_q) begin
        if (rise || tmr_q == '0) rdy_n_d = 1'b1;
        else                     tmr_d   = tmr_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '1;
      tmr_q   <= '0;
      rdy_n_q <= 1'b1;
      hclk_q  <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      tmr_q   <= tmr_d;
      rdy_n_q <= rdy_n_d;
      hclk_q  <= hclk_s_i;
    end
  end

  assign sdata_o = hold_q[0];
  assign rdy_n_o = rdy_n_q;

  // R4
  load_sets_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !rdy_n_q);
  // R5
  host_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_n_q && rise && !load_i) |=> rdy_n_q);
  // R6
  rdy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_n_q) |-> $past(load_i));
  // R6
  tmr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_n_q |-> (tmr_q < TW'(READY_CYC)));
  // R7
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !load_i) |=> (hold_q == {1'b1, $past(hold_q[DATA_W-1:1])}));
  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && !load_i) |=> $stable(hold_q));
endmodule

// File: rtl/async_byte_framer.sv
module async_byte_framer #(
  parameter int unsigned OSR       = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned READY_CYC = OSR / 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic rx_bit_i,
  input  logic hclk_i,
  output logic sdata_o,
  output logic rdy_n_o,
  output logic ferr_o
);
  logic [1:0]        sync_q;
  logic              rx_s;
  logic              hclk_s;
  logic              done;
  logic              ferr;
  logic [DATA_W-1:0] rx_byte;

  abf_sync #(.W(2), .STAGES(2), .RST_VAL(2'b01)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({hclk_i, rx_bit_i}),
    .q_o   (sync_q)
  );
  assign rx_s   = sync_q[0];
  assign hclk_s = sync_q[1];

  abf_rx #(.OSR(OSR), .DATA_W(DATA_W)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en_i),
    .rx_s_i (rx_s),
    .done_o (done),
    .ferr_o (ferr),
    .byte_o (rx_byte)
  );

  abf_readout #(.DATA_W(DATA_W), .READY_CYC(READY_CYC)) u_readout (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (done),
    .din_i    (rx_byte),
    .hclk_s_i (hclk_s),
    .sdata_o  (sdata_o),
    .rdy_n_o  (rdy_n_o)
  );

  assign ferr_o = ferr;

  // R3
  ferr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ferr_o |=> !ferr_o);
  // R3
  ferr_no_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ferr_o |=> rdy_n_o || $past(!rdy_n_o));
endmodule

// File: tb/async_byte_framer_bench.sv
module async_byte_framer_bench;
  localparam int OSR       = 16;
  localparam int READY_CYC = OSR / 2;
  localparam time CLK_PER  = 10ns;

  // bit 8 = stop bit level, bits 7:0 = data byte
  localparam logic [8:0] VEC [0:5] = '{9'h1A5, 9'h100, 9'h1FF, 9'h03C, 9'h181, 9'h15A};

  logic clk = 1'b0;
  logic rst_n, en, rx_bit, hclk;
  logic sdata, rdy_n, ferr;
  int   errs = 0, checks = 0;
  int   rdy_falls = 0, ferr_cyc = 0, low_run = 0, last_w = 0;
  logic rdy_prev = 1'b1;

  always #(CLK_PER/2) clk = ~clk;

  async_byte_framer #(.OSR(OSR), .READY_CYC(READY_CYC)) u_async_byte_framer (
    .clk(clk), .rst_n(rst_n), .en_i(en), .rx_bit_i(rx_bit), .hclk_i(hclk),
    .sdata_o(sdata), .rdy_n_o(rdy_n), .ferr_o(ferr)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (rdy_prev && !rdy_n) rdy_falls++;
      if (ferr) ferr_cyc++;
      if (!rdy_n) low_run++;
      else if (!rdy_prev) begin last_w = low_run; low_run = 0; end
      rdy_prev = rdy_n;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic stop, input int tail_low);
    logic [9:0] fr;
    fr = {stop, b, 1'b0};
    for (int j = 0; j < 10; j++) begin
      rx_bit = fr[j];
      repeat (OSR) @(negedge clk);
    end
    if (tail_low > 0) begin
      rx_bit = 1'b0;
      repeat (tail_low) @(negedge clk);
    end
    rx_bit = 1'b1;
    repeat (OSR) @(negedge clk);
  endtask

  task automatic read_bits(input int n, output logic [8:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      got[i] = sdata;
      hclk = 1'b1;
      repeat (4) @(negedge clk);
      hclk = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    int f0, e0;
    logic [8:0] got;
    rst_n = 1'b0; en = 1'b1; rx_bit = 1'b1; hclk = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(rdy_n === 1'b1, "R11 rdy_n", rdy_n, 1);
    chk(ferr === 1'b0, "R11 ferr", ferr, 0);
    chk(sdata === 1'b1, "R11 sdata", sdata, 1);
    rst_n = 1'b1;
    repeat (OSR) @(negedge clk);

    // Table walk: R1 R3 R4 R6 R7
    for (int v = 0; v < 6; v++) begin
      f0 = rdy_falls; e0 = ferr_cyc;
      send(VEC[v][7:0], VEC[v][8], 0);
      if (VEC[v][8]) begin
        chk(rdy_falls == f0 + 1, "R4 ready falls", rdy_falls - f0, 1);
        chk(last_w == READY_CYC, "R6 ready width", last_w, READY_CYC);
        chk(ferr_cyc == e0, "R3 no ferr on good", ferr_cyc - e0, 0);
        read_bits(9, got);
        chk(got[7:0] == VEC[v][7:0], "R1 byte LSB first", got[7:0], VEC[v][7:0]);
        chk(got[8] == 1'b1, "R7 ones after b7", got[8], 1);
      end else begin
        chk(rdy_falls == f0, "R3 no ready on bad stop", rdy_falls - f0, 0);
        chk(ferr_cyc == e0 + 1, "R3 ferr one clock", ferr_cyc - e0, 1);
      end
    end

    // R2 glitch on start bit
    f0 = rdy_falls; e0 = ferr_cyc;
    rx_bit = 1'b0; repeat (4) @(negedge clk);
    rx_bit = 1'b1; repeat (20 * OSR) @(negedge clk);
    chk(rdy_falls == f0, "R2 glitch no ready", rdy_falls - f0, 0);
    chk(ferr_cyc == e0, "R2 glitch no ferr", ferr_cyc - e0, 0);

    // R10 line stays low after bad stop bit
    f0 = rdy_falls; e0 = ferr_cyc;
    send(8'h00, 1'b0, 14 * OSR);
    chk(ferr_cyc == e0 + 1, "R10 single ferr", ferr_cyc - e0, 1);
    chk(rdy_falls == f0, "R10 no ready", rdy_falls - f0, 0);

    // R9 disabled receiver
    en = 1'b0;
    f0 = rdy_falls; e0 = ferr_cyc;
    send(8'h3C, 1'b1, 0);
    send(8'h55, 1'b0, 0);
    chk(rdy_falls == f0, "R9 no ready when off", rdy_falls - f0, 0);
    chk(ferr_cyc == e0, "R9 no ferr when off", ferr_cyc - e0, 0);
    en = 1'b1;
    repeat (OSR) @(negedge clk);

    // R5 host edge clears ready early; readout continues at b1
    fork
      send(8'hC6, 1'b1, 0);
      begin
        int t = 0;
        while (rdy_n !== 1'b0 && t < 400) begin @(negedge clk); t++; end
        hclk = 1'b1;
        repeat (6) @(negedge clk);
        hclk = 1'b0;
      end
    join
    chk(last_w == 3, "R5 host clear width", last_w, 3);
    read_bits(7, got);
    chk(got[6:0] == 7'(8'hC6 >> 1), "R7 bits after first edge", got[6:0], 8'hC6 >> 1);

    // R8 readout of stored byte during next reception
    send(8'h96, 1'b1, 0);
    fork
      send(8'h4B, 1'b1, 0);
      read_bits(4, got);
    join
    chk(got[3:0] == 4'h6, "R8 old byte during rx", got[3:0], 4'h6);
    read_bits(8, got);
    chk(got[7:0] == 8'h4B, "R8 new byte after stop", got[7:0], 8'h4B);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule